// File: doc/BRIEF.md
# Three-Mode Byte DMA Channel

This block is a single DMA channel. Software sets it up through a small register window and then starts it with a write to the command register. It moves data one byte per beat between a memory request port and a streaming peripheral port. The command picks one of three address patterns:

- one contiguous run;
- two runs, each starting at its own base address;
- a set of equal-width lines, where a stride is added from one line start to the next.

One command bit selects the direction. Another marks the segment as the last in a chain, and a finished last segment raises a sticky interrupt.

The count register holds two 13-bit length fields. The second-base register serves as a second run address in one mode and as a line stride in the rectangular mode. The command write copies all setup registers into a working snapshot. Software can therefore reload the window while a transfer is still running.

Top module: `dmx_channel`

## Requirements
- R1: Register byte offsets are 0 (base address), 4 (count), 8 (second base or stride), 12 (command) and 16 (status clear). A write to offset 12 while idle starts a transfer, and `busy` is high from the next cycle.
- R2: Command bits [1:0] = 1 selects single mode. count[12:0] bytes are moved at consecutive ascending addresses from the base address.
- R3: Command bits [1:0] = 2 selects double mode. First, count[12:0] bytes are moved from the base address. Then count[28:16] bytes are moved from the offset-8 address.
- R4: Command bits [1:0] = 3 selects rectangular mode. count[28:16] lines of count[12:0] bytes each are moved. Each line start is the previous line start plus the offset-8 value.
- R5: A zero run length, zero line width, zero line count, or command bits [1:0] = 0 completes the affected part with no memory beats. Double mode still runs a non-empty second run after an empty first run.
- R6: Command bit 2 set makes the end of the transfer set `irq`. With bit 2 clear, `irq` stays low.
- R7: `irq` is a sticky level. It is cleared only by writing a value with bit 0 = 1 to offset 16.
- R8: A command write while `busy` is ignored. Register writes made while `busy` do not change the running transfer, and they are used by the next command.
- R9: Command bit 3 selects direction: 0 reads memory into `per_out_data`, and 1 writes `per_in_data` to memory. A beat happens only in a cycle with `mem_req` and `mem_gnt` both high. `mem_req` waits for `per_out_ready` (reads) or `per_in_valid` (writes).
- R10: `busy` stays high from the command write until the transfer completes. `mem_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Sticky completion interrupt |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write to memory |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte read from memory, valid with grant |
| mem_gnt | input | 1 | Memory accepts the beat this cycle |
| per_out_valid | output | 1 | Read byte is presented to the peripheral |
| per_out_ready | input | 1 | Peripheral can take a byte |
| per_out_data | output | 8 | Byte to the peripheral |
| per_in_valid | input | 1 | Peripheral offers a byte |
| per_in_ready | output | 1 | Offered byte is consumed |
| per_in_data | input | 8 | Byte from the peripheral |

## Verification
The modes are tried with distinct address and count patterns. A non-zero first run whose second run sits elsewhere separates correct double-mode sequencing from a mode that stops after one run. A three-line rectangle with a stride larger than its width shows whether the stride is applied to line starts and not to the running pointer. Zero-length first runs, zero second runs, zero line counts and a maximum-length run separate correct skipping from off-by-one counting. Stalled grants and stalled peripheral handshakes, with a command written in the middle, check that a running transfer neither restarts nor picks up new register values.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DOUBLE = 2'd2,
    MODE_RECT   = 2'd3
  } dmx_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_MOVE,
    SQ_STEP,
    SQ_FIN
  } dmx_state_e;

  localparam int OFF_BASE_A = 0;
  localparam int OFF_COUNT  = 4;
  localparam int OFF_BASE_B = 8;
  localparam int OFF_CMD    = 12;
  localparam int OFF_CLEAR  = 16;

  localparam int CMD_LAST_BIT = 2;
  localparam int CMD_DIR_BIT  = 3;
  localparam int CNT_HI_LSB   = 16;

endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic              seq_done,
  output logic              start,
  output logic [ADDR_W-1:0] run_base_a,
  output logic [ADDR_W-1:0] run_base_b,
  output logic [LEN_W-1:0]  run_len_a,
  output logic [LEN_W-1:0]  run_len_b,
  output dmx_mode_e         run_mode,
  output logic              run_dir,
  output logic              irq
);

  logic [ADDR_W-1:0] base_a_q, base_b_q;
  logic [31:0]       count_q;
  logic              run_last;
  logic              hit_cmd, hit_clr;

  assign hit_cmd = reg_wr && (reg_off == OFF_W'(OFF_CMD));
  assign hit_clr = reg_wr && (reg_off == OFF_W'(OFF_CLEAR)) && reg_wdata[0];
  assign start   = hit_cmd && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_b_q <= '0;
      count_q  <= '0;
    end else if (reg_wr) begin
      if (reg_off == OFF_W'(OFF_BASE_A)) base_a_q <= reg_wdata[ADDR_W-1:0];
      if (reg_off == OFF_W'(OFF_BASE_B)) base_b_q <= reg_wdata[ADDR_W-1:0];
      if (reg_off == OFF_W'(OFF_COUNT))  count_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_base_a <= '0;
      run_base_b <= '0;
      run_len_a  <= '0;
      run_len_b  <= '0;
      run_mode   <= MODE_NONE;
      run_dir    <= 1'b0;
      run_last   <= 1'b0;
    end else if (start) begin
      run_base_a <= base_a_q;
      run_base_b <= base_b_q;
      run_len_a  <= count_q[LEN_W-1:0];
      run_len_b  <= count_q[CNT_HI_LSB +: LEN_W];
      run_mode   <= dmx_mode_e'(reg_wdata[1:0]);
      run_dir    <= reg_wdata[CMD_DIR_BIT];
      run_last   <= reg_wdata[CMD_LAST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq <= 1'b0;
    else if (seq_done && run_last) irq <= 1'b1;
    else if (hit_clr)            irq <= 1'b0;
  end

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] run_base_a,
  input  logic [ADDR_W-1:0] run_base_b,
  input  logic [LEN_W-1:0]  run_len_a,
  input  logic [LEN_W-1:0]  run_len_b,
  input  dmx_mode_e         run_mode,
  input  logic              fire,
  output logic              active,
  output logic              busy,
  output logic              seq_done,
  output logic [ADDR_W-1:0] cur_addr
);

  dmx_state_e        state;
  logic              seg_b;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  lines_left;
  logic [ADDR_W-1:0] line_base;

  function automatic logic [ADDR_W-1:0] next_line(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] stride);
    return base + stride;
  endfunction

  function automatic logic rect_empty(input logic [LEN_W-1:0] width,
                                      input logic [LEN_W-1:0] lines);
    return (width == '0) || (lines == '0);
  endfunction

  assign active   = (state == SQ_MOVE);
  assign busy     = (state != SQ_IDLE);
  assign seq_done = (state == SQ_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      seg_b      <= 1'b0;
      remain     <= '0;
      lines_left <= '0;
      line_base  <= '0;
      cur_addr   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (start) state <= SQ_LOAD;
        SQ_LOAD: begin
          seg_b      <= 1'b0;
          line_base  <= run_base_a;
          cur_addr   <= run_base_a;
          remain     <= run_len_a;
          lines_left <= (run_mode == MODE_RECT) ? run_len_b : LEN_W'(1);
          if (run_mode == MODE_NONE)                                    state <= SQ_FIN;
          else if (run_mode == MODE_RECT && rect_empty(run_len_a, run_len_b)) state <= SQ_FIN;
          else if (run_len_a == '0)                                     state <= SQ_STEP;
          else                                                          state <= SQ_MOVE;
        end
        SQ_MOVE: if (fire) begin
          cur_addr <= cur_addr + ADDR_W'(1);
          remain   <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) state <= SQ_STEP;
        end
        SQ_STEP: begin
          if (run_mode == MODE_DOUBLE && !seg_b) begin
            seg_b    <= 1'b1;
            cur_addr <= run_base_b;
            remain   <= run_len_b;
            state    <= (run_len_b == '0) ? SQ_FIN : SQ_MOVE;
          end else if (run_mode == MODE_RECT && lines_left > LEN_W'(1)) begin
            line_base  <= next_line(line_base, run_base_b);
            cur_addr   <= next_line(line_base, run_base_b);
            lines_left <= lines_left - LEN_W'(1);
            remain     <= run_len_a;
            state      <= SQ_MOVE;
          end else begin
            state <= SQ_FIN;
          end
        end
        SQ_FIN:  state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dmx_port.sv
module dmx_port #(
  parameter int DATA_W = 8
) (
  input  logic              active,
  input  logic              dir_in,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              per_out_ready,
  input  logic              per_in_valid,
  input  logic [DATA_W-1:0] per_in_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              per_out_valid,
  output logic [DATA_W-1:0] per_out_data,
  output logic              per_in_ready,
  output logic              fire
);

  logic side_ok;

  assign side_ok       = dir_in ? per_in_valid : per_out_ready;
  assign mem_req       = active && side_ok;
  assign mem_we        = dir_in;
  assign mem_wdata     = per_in_data;
  assign fire          = mem_req && mem_gnt;
  assign per_out_valid = fire && !dir_in;
  assign per_out_data  = mem_rdata;
  assign per_in_ready  = fire && dir_in;

endmodule

// File: rtl/dmx_channel.sv
module dmx_channel
  import dmx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [31:0]       reg_wdata,
  output logic              busy,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_gnt,
  output logic              per_out_valid,
  input  logic              per_out_ready,
  output logic [DATA_W-1:0] per_out_data,
  input  logic              per_in_valid,
  output logic              per_in_ready,
  input  logic [DATA_W-1:0] per_in_data
);

  logic              start, seq_done, active, fire, run_dir;
  logic [ADDR_W-1:0] run_base_a, run_base_b;
  logic [LEN_W-1:0]  run_len_a, run_len_b;
  dmx_mode_e         run_mode;

  dmx_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .busy(busy), .seq_done(seq_done), .start(start),
    .run_base_a(run_base_a), .run_base_b(run_base_b), .run_len_a(run_len_a),
    .run_len_b(run_len_b), .run_mode(run_mode), .run_dir(run_dir), .irq(irq)
  );

  dmx_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .run_base_a(run_base_a),
    .run_base_b(run_base_b), .run_len_a(run_len_a), .run_len_b(run_len_b),
    .run_mode(run_mode), .fire(fire), .active(active), .busy(busy),
    .seq_done(seq_done), .cur_addr(mem_addr)
  );

  dmx_port #(.DATA_W(DATA_W)) u_port (
    .active(active), .dir_in(run_dir), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .per_out_ready(per_out_ready), .per_in_valid(per_in_valid),
    .per_in_data(per_in_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .per_out_valid(per_out_valid),
    .per_out_data(per_out_data), .per_in_ready(per_in_ready), .fire(fire)
  );

endmodule

// File: rtl/dmx_channel_chk.sv
module dmx_channel_chk #(
  parameter int OFF_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [OFF_W-1:0] reg_off,
  input logic [31:0]      reg_wdata,
  input logic             busy,
  input logic             irq,
  input logic             mem_req,
  input logic             mem_we,
  input logic             per_out_ready,
  input logic             seq_done
);

  // R10
  busy_covers_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R1
  start_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_off == OFF_W'(12)));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_off == OFF_W'(16) && reg_wdata[0])) |=> irq);

  // R6
  irq_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(seq_done));

  // R5
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !mem_req);

  // R9
  read_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> per_out_ready);

endmodule

bind dmx_channel dmx_channel_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
  .reg_wdata(reg_wdata), .busy(busy), .irq(irq), .mem_req(mem_req),
  .mem_we(mem_we), .per_out_ready(per_out_ready), .seq_done(seq_done)
);

// File: tb/dmx_channel_test.sv
module dmx_channel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_off = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, irq, mem_req, mem_we, per_out_valid, per_in_ready;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata, per_out_data, per_in_data;
  logic        mem_gnt = 1'b1;
  logic        per_out_ready = 1'b1;
  logic        per_in_valid = 1'b1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int beats = 0;
  int data_err = 0;
  longint addr_sum = 0;
  logic [31:0] first_a = '0, last_a = '0;

  always #2.5 clk = ~clk;

  assign mem_rdata   = mem_addr[7:0] ^ 8'h5A;
  assign per_in_data = 8'(cyc) ^ 8'hC3;

  dmx_channel uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .busy(busy), .irq(irq), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .per_out_valid(per_out_valid),
    .per_out_ready(per_out_ready), .per_out_data(per_out_data),
    .per_in_valid(per_in_valid), .per_in_ready(per_in_ready),
    .per_in_data(per_in_data)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] base;
    logic [31:0] cnt;
    logic [31:0] aux;
    logic [15:0] n;
    logic [31:0] first;
    logic [31:0] last;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'h5, 32'h1000, 32'h0000_0005, 32'h0,    16'd5,    32'h1000, 32'h1004, 1'b1},
    '{4'h6, 32'h2000, 32'h0002_0003, 32'h3000, 16'd5,    32'h2000, 32'h3001, 1'b1},
    '{4'h7, 32'h4000, 32'h0003_0004, 32'h10,   16'd12,   32'h4000, 32'h4023, 1'b1},
    '{4'h6, 32'h0100, 32'h0004_0000, 32'h5000, 16'd4,    32'h5000, 32'h5003, 1'b1},
    '{4'h5, 32'h0,    32'h0,         32'h0,    16'd0,    32'h0,    32'h0,    1'b1},
    '{4'h7, 32'h9000, 32'h0000_0008, 32'h10,   16'd0,    32'h0,    32'h0,    1'b1},
    '{4'h1, 32'h6000, 32'h0000_0002, 32'h0,    16'd2,    32'h6000, 32'h6001, 1'b0},
    '{4'hD, 32'h7000, 32'h0000_0003, 32'h0,    16'd3,    32'h7000, 32'h7002, 1'b1},
    '{4'h6, 32'h8000, 32'h0000_0002, 32'h0,    16'd2,    32'h8000, 32'h8001, 1'b1},
    '{4'hF, 32'hA000, 32'h0002_0002, 32'h100,  16'd4,    32'hA000, 32'hA101, 1'b1},
    '{4'h5, 32'hB000, 32'h0000_1FFF, 32'h0,    16'd8191, 32'hB000, 32'hCFFE, 1'b1},
    '{4'h4, 32'hF000, 32'h0000_0007, 32'h0,    16'd0,    32'h0,    32'h0,    1'b1}
  };

  // Independent model: sum of all beat addresses for a command.
  function automatic longint model_sum(input logic [1:0] mode, input logic [31:0] base,
                                       input logic [31:0] cnt, input logic [31:0] aux);
    longint s = 0;
    int lo = int'(cnt[12:0]);
    int hi = int'(cnt[28:16]);
    if (mode == 2'd1 || mode == 2'd2)
      for (int i = 0; i < lo; i++) s += longint'(base) + i;
    if (mode == 2'd2)
      for (int i = 0; i < hi; i++) s += longint'(aux) + i;
    if (mode == 2'd3)
      for (int l = 0; l < hi; l++)
        for (int i = 0; i < lo; i++) s += longint'(base) + longint'(aux) * l + i;
    return s;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Beat monitor (R9 data path)
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      if (beats == 0) first_a = mem_addr;
      last_a = mem_addr;
      addr_sum += longint'(mem_addr);
      beats++;
      if (mem_we) begin
        if (mem_wdata !== per_in_data || per_in_ready !== 1'b1 || per_out_valid !== 1'b0)
          data_err++;
      end else begin
        if (per_out_data !== mem_rdata || per_out_valid !== 1'b1 || per_in_ready !== 1'b0)
          data_err++;
      end
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic clr_mon();
    beats = 0; addr_sum = 0; data_err = 0; first_a = '0; last_a = '0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 20000) begin @(negedge clk); k++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 R7 reset state
    check("R10 reset busy", longint'(busy), 0);
    check("R7 reset irq", longint'(irq), 0);
    check("R10 reset mem_req", longint'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      wr(5'd16, 32'h1);
      check("R7 irq cleared", longint'(irq), 0);
      wr(5'd0, VECS[v].base);
      wr(5'd4, VECS[v].cnt);
      wr(5'd8, VECS[v].aux);
      clr_mon();
      wr(5'd12, {28'h0, VECS[v].cmd});
      check("R1 busy after command", longint'(busy), 1);
      wait_idle();
      repeat (2) @(negedge clk);
      // R2 R3 R4 R5 beat count per mode
      check($sformatf("R2/R3/R4/R5 beats vec %0d", v), beats, longint'(VECS[v].n));
      if (VECS[v].n != 0) begin
        check($sformatf("R2 R3 R4 first addr vec %0d", v), longint'(first_a), longint'(VECS[v].first));
        check($sformatf("R2 R3 R4 last addr vec %0d", v), longint'(last_a), longint'(VECS[v].last));
      end
      check($sformatf("R4 address sum vec %0d", v), addr_sum,
            model_sum(VECS[v].cmd[1:0], VECS[v].base, VECS[v].cnt, VECS[v].aux));
      check($sformatf("R9 data path vec %0d", v), data_err, 0);
      check($sformatf("R6 irq vec %0d", v), longint'(irq), longint'(VECS[v].irq));
    end

    // R7 sticky over idle cycles, then clear
    repeat (10) @(negedge clk);
    check("R7 irq held", longint'(irq), 1);
    wr(5'd16, 32'h0);
    check("R7 clear needs bit0", longint'(irq), 1);
    wr(5'd16, 32'h1);
    check("R7 irq cleared by write", longint'(irq), 0);

    // R8 command and register writes while busy
    mem_gnt = 1'b0;
    wr(5'd0, 32'hC000);
    wr(5'd4, 32'h6);
    clr_mon();
    wr(5'd12, 32'h5);
    wr(5'd0, 32'hD000);
    wr(5'd4, 32'h1);
    wr(5'd12, 32'h5);
    check("R8 still busy", longint'(busy), 1);
    mem_gnt = 1'b1;
    wait_idle();
    repeat (2) @(negedge clk);
    check("R8 beats of first command", beats, 6);
    check("R8 first addr", longint'(first_a), 32'hC000);
    check("R8 last addr", longint'(last_a), 32'hC005);
    clr_mon();
    wr(5'd12, 32'h5);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R8 new regs used next", beats, 1);
    check("R8 new base used next", longint'(last_a), 32'hD000);

    // R9 peripheral stall holds reads
    per_out_ready = 1'b0;
    wr(5'd0, 32'hE000);
    wr(5'd4, 32'h3);
    clr_mon();
    wr(5'd12, 32'h5);
    repeat (5) @(negedge clk);
    check("R9 no beat while peripheral stalls", beats, 0);
    check("R10 busy while stalled", longint'(busy), 1);
    per_out_ready = 1'b1;
    wait_idle();
    repeat (2) @(negedge clk);
    check("R9 beats after stall", beats, 3);
    check("R9 data after stall", data_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule